// File: doc/BRIEF.md
# Phase-Detector Pulse-Width Lock Detector

This block decides whether a phase-locked loop has settled by watching the correction pulses that its phase-frequency detector produces. A fast sampling clock counts how many of its own cycles each of the up and down lines stays high. A one-cycle strobe marks the end of every detector cycle. At that strobe the wider of the two pulses is compared against a window expressed in sampling-clock counts.

A settled loop produces matched, very short pulses on both lines, so a short nonzero width still counts as settled. The lock flag is set after an unbroken run of in-window detector cycles. It is cleared after an unbroken run of out-of-window cycles, and it holds its value between those two events. The window either comes straight from a programmable value or from a two-setting preset chosen by one bit of a control byte. The wide preset is three times the narrow one.

Top module: `pd_lock_detect`

## Requirements
- R1: While reset is low and after its release, the lock output is 0 and both run counters are 0.
- R2: A detector cycle's width is the larger of the up count and the down count, where each count is the number of non-strobe sampling cycles since the previous strobe in which that line was high. The cycle is in-window when width <= window. A zero width is therefore always in-window, and any nonzero width is out-of-window when the window is 0.
- R3: The lock output goes to 1 on the clock edge of the strobe that completes RUN_LEN (default 3) consecutive in-window detector cycles.
- R4: The lock output goes to 0 on the clock edge of the strobe that completes RUN_LEN consecutive out-of-window detector cycles.
- R5: An in-window cycle clears the out-of-window run and an out-of-window cycle clears the in-window run. Both runs saturate at RUN_LEN, and the lock output changes on no other event.
- R6: With the preset source selected (use_preset_i = 1), ctl_byte_i bit 2 picks the window: 0 gives 2*UNIT counts and 1 gives 6*UNIT counts. All other bits of the byte are ignored.
- R7: With the register source selected (use_preset_i = 0), the window is win_cfg_i in sampling-clock counts.
- R8: A cycle in which the effective window differs from its value in the previous cycle clears both runs and leaves the lock output unchanged. A strobe in that same cycle is discarded.
- R9: Each pulse counter saturates at 2^CNT_W-1, so a longer pulse measures as that maximum.
- R10: Line samples taken in the strobe cycle itself are not counted, and both counters restart from 0 after every strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_i | input | 1 | Up correction pulse from the phase detector |
| dn_i | input | 1 | Down correction pulse from the phase detector |
| cyc_strobe_i | input | 1 | One-cycle end-of-detector-cycle marker |
| win_cfg_i | input | CNT_W | Programmable window in sampling-clock counts |
| use_preset_i | input | 1 | 1 selects the preset window, 0 selects win_cfg_i |
| ctl_byte_i | input | 8 | Control byte; bit 2 chooses narrow or wide preset |
| lock_o | output | 1 | Registered lock flag |

## Verification
The bench sets CNT_W to 6, UNIT to 2 and keeps RUN_LEN at 3. With these values the presets are 4 and 12 counts. A 70-cycle pulse then drives the counters into saturation at 63, and a window of 63 tells the saturated measurement apart from the true width. The short windows keep every boundary case, such as width equal to the window, width one above it, or a zero window, within a few dozen sampling cycles per detector cycle.

// File: rtl/pd_lock_pkg.sv
package pd_lock_pkg;

    // Window source selection
    typedef enum logic {
        WSRC_REG    = 1'b0,
        WSRC_PRESET = 1'b1
    } win_src_e;

    // Preset window sizes in delay units
    localparam int NARROW_UNITS = 2;
    localparam int WIDE_UNITS   = 6;

    // Control-byte bit that chooses the wide preset
    localparam int MODE_BIT = 2;

endpackage

// File: rtl/pd_pulse_meter.sv
module pd_pulse_meter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } meter_t;

    meter_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (pulse_i && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_MAX && !clr_i) |=> (st_q.cnt == CNT_MAX)); // R9

    AST_CNT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.cnt == '0)); // R10

endmodule

// File: rtl/pd_window_sel.sv
module pd_window_sel
    import pd_lock_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int UNIT  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] win_cfg_i,
    input  logic             use_preset_i,
    input  logic [7:0]       ctl_byte_i,
    output logic [CNT_W-1:0] win_o,
    output logic             chg_o
);

    localparam logic [CNT_W-1:0] WIN_NARROW = CNT_W'(NARROW_UNITS * UNIT);
    localparam logic [CNT_W-1:0] WIN_WIDE   = CNT_W'(WIDE_UNITS * UNIT);

    typedef struct packed {
        logic [CNT_W-1:0] win_prev;
    } wsel_t;

    wsel_t            st_d, st_q;
    logic [CNT_W-1:0] win_eff;
    win_src_e         src;

    always_comb begin
        src = win_src_e'(use_preset_i);
        if (src == WSRC_PRESET) begin
            win_eff = ctl_byte_i[MODE_BIT] ? WIN_WIDE : WIN_NARROW;
        end else begin
            win_eff = win_cfg_i;
        end
        st_d          = st_q;
        st_d.win_prev = win_eff;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign win_o = win_eff;
    assign chg_o = (win_eff != st_q.win_prev);

    AST_PRESET_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        use_preset_i |-> (win_o == WIN_NARROW || win_o == WIN_WIDE)); // R6

endmodule

// File: rtl/pd_lock_run.sv
module pd_lock_run #(
    parameter int CNT_W   = 8,
    parameter int RUN_LEN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_i,
    input  logic [CNT_W-1:0] width_i,
    input  logic [CNT_W-1:0] win_i,
    input  logic             chg_i,
    output logic             lock_o
);

    localparam int            RUN_W   = $clog2(RUN_LEN + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LEN);

    typedef struct packed {
        logic [RUN_W-1:0] in_run;
        logic [RUN_W-1:0] out_run;
        logic             lock;
    } run_t;

    run_t st_d, st_q;
    logic in_win;

    // Zero width satisfies width <= window for every window, including 0
    assign in_win = (width_i <= win_i);

    always_comb begin
        st_d = st_q;
        if (chg_i) begin
            st_d.in_run  = '0;
            st_d.out_run = '0;
        end else if (strobe_i) begin
            if (in_win) begin
                st_d.out_run = '0;
                if (st_q.in_run != RUN_MAX) begin
                    st_d.in_run = st_q.in_run + 1'b1;
                end
                if (st_q.in_run >= RUN_MAX - 1'b1) begin
                    st_d.lock = 1'b1;
                end
            end else begin
                st_d.in_run = '0;
                if (st_q.out_run != RUN_MAX) begin
                    st_d.out_run = st_q.out_run + 1'b1;
                end
                if (st_q.out_run >= RUN_MAX - 1'b1) begin
                    st_d.lock = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_o = st_q.lock;

    AST_LOCK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.lock) |-> $past(strobe_i && in_win && !chg_i)); // R3

    AST_LOCK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.lock) |-> $past(strobe_i && !in_win && !chg_i)); // R4

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe_i && !chg_i) |=> $stable(st_q.lock)); // R5

    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.in_run <= RUN_MAX) && (st_q.out_run <= RUN_MAX)); // R5

    AST_RUN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.in_run == '0) || (st_q.out_run == '0)); // R5

    AST_WIN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        chg_i |=> (st_q.in_run == '0 && st_q.out_run == '0 && $stable(st_q.lock))); // R8

endmodule

// File: rtl/pd_lock_detect.sv
module pd_lock_detect #(
    parameter int CNT_W   = 8,
    parameter int UNIT    = 4,
    parameter int RUN_LEN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_i,
    input  logic             dn_i,
    input  logic             cyc_strobe_i,
    input  logic [CNT_W-1:0] win_cfg_i,
    input  logic             use_preset_i,
    input  logic [7:0]       ctl_byte_i,
    output logic             lock_o
);

    localparam int N_LINES = 2;

    logic [N_LINES-1:0] lines;
    logic [CNT_W-1:0]   line_cnt [N_LINES];
    logic [CNT_W-1:0]   width;
    logic [CNT_W-1:0]   win;
    logic               win_chg;

    assign lines = {dn_i, up_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_meter
        pd_pulse_meter #(
            .CNT_W (CNT_W)
        ) i_meter (
            .clk     (clk),
            .rst_n   (rst_n),
            .pulse_i (lines[g]),
            .clr_i   (cyc_strobe_i),
            .cnt_o   (line_cnt[g])
        );
    end

    assign width = (line_cnt[0] > line_cnt[1]) ? line_cnt[0] : line_cnt[1];

    pd_window_sel #(
        .CNT_W (CNT_W),
        .UNIT  (UNIT)
    ) i_wsel (
        .clk          (clk),
        .rst_n        (rst_n),
        .win_cfg_i    (win_cfg_i),
        .use_preset_i (use_preset_i),
        .ctl_byte_i   (ctl_byte_i),
        .win_o        (win),
        .chg_o        (win_chg)
    );

    pd_lock_run #(
        .CNT_W   (CNT_W),
        .RUN_LEN (RUN_LEN)
    ) i_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (cyc_strobe_i),
        .width_i  (width),
        .win_i    (win),
        .chg_i    (win_chg),
        .lock_o   (lock_o)
    );

    AST_RESET_LOCK: assert property (@(posedge clk)
        !rst_n |=> !lock_o); // R1

endmodule

// File: tb/test_pd_lock_detect.sv
module test_pd_lock_detect;

    localparam int CNT_W   = 6;
    localparam int UNIT    = 2;
    localparam int RUN_LEN = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             up = 1'b0;
    logic             dn = 1'b0;
    logic             strobe = 1'b0;
    logic [CNT_W-1:0] win_cfg = 6'd5;
    logic             use_preset = 1'b0;
    logic [7:0]       ctl = 8'h00;
    logic             lock;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pd_lock_detect #(
        .CNT_W   (CNT_W),
        .UNIT    (UNIT),
        .RUN_LEN (RUN_LEN)
    ) i_pd_lock_detect (
        .clk          (clk),
        .rst_n        (rst_n),
        .up_i         (up),
        .dn_i         (dn),
        .cyc_strobe_i (strobe),
        .win_cfg_i    (win_cfg),
        .use_preset_i (use_preset),
        .ctl_byte_i   (ctl),
        .lock_o       (lock)
    );

    task automatic check_lock(input logic exp, input string tag);
        tests++;
        if (lock !== exp) begin
            fails++;
            $display("FAIL %s: lock actual=%b expected=%b", tag, lock, exp);
        end
    endtask

    // One detector cycle: up high u cycles, then dn high d cycles, then strobe.
    // Called and returns at a falling edge; lock is sampled after the strobe edge.
    task automatic pd_cycle(input int u, input int d, input logic up_at_strobe);
        for (int i = 0; i < u; i++) begin
            up = 1'b1;
            @(negedge clk);
        end
        up = 1'b0;
        for (int i = 0; i < d; i++) begin
            dn = 1'b1;
            @(negedge clk);
        end
        dn = 1'b0;
        up = up_at_strobe;
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        up = 1'b0;
    endtask

    task automatic run_n(input int n, input int u, input int d);
        for (int i = 0; i < n; i++) pd_cycle(u, d, 1'b0);
    endtask

    task automatic set_reg_win(input logic [CNT_W-1:0] v);
        use_preset = 1'b0;
        win_cfg = v;
        @(negedge clk);
    endtask

    task automatic set_preset(input logic [7:0] b);
        use_preset = 1'b1;
        ctl = b;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check_lock(1'b0, "R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_lock(1'b0, "R1 after reset");
    endtask

    task automatic t_acquire();
        set_reg_win(6'd5);
        pd_cycle(3, 3, 1'b0);
        check_lock(1'b0, "R3 one in-window cycle");
        pd_cycle(1, 3, 1'b0);
        check_lock(1'b0, "R3 two in-window cycles");
        pd_cycle(3, 1, 1'b0);
        check_lock(1'b1, "R3 third in-window cycle, R2 max not sum");
    endtask

    task automatic t_boundary();
        run_n(3, 5, 0);
        check_lock(1'b1, "R2 width equal to window is in-window");
        run_n(2, 6, 2);
        check_lock(1'b1, "R5 two out-of-window cycles hold lock");
        pd_cycle(0, 5, 1'b0);
        check_lock(1'b1, "R5 in-window cycle breaks out run");
        run_n(2, 6, 0);
        check_lock(1'b1, "R5 out run restarted after break");
        pd_cycle(2, 6, 1'b0);
        check_lock(1'b0, "R4 third out-of-window cycle clears lock");
    endtask

    task automatic t_strobe_sample();
        pd_cycle(5, 0, 1'b1);
        pd_cycle(5, 0, 1'b1);
        check_lock(1'b0, "R10 two cycles with up high at strobe");
        pd_cycle(5, 0, 1'b1);
        check_lock(1'b1, "R10 strobe-cycle sample not counted");
    endtask

    task automatic t_win_change();
        run_n(2, 7, 0);
        set_reg_win(6'd6);
        check_lock(1'b1, "R8 window change keeps lock");
        set_reg_win(6'd5);
        run_n(2, 7, 0);
        check_lock(1'b1, "R8 out run cleared by window change");
        pd_cycle(7, 0, 1'b0);
        check_lock(1'b0, "R4 lock clears after fresh out run");
        run_n(2, 3, 0);
        set_reg_win(6'd6);
        check_lock(1'b0, "R8 window change keeps lock low");
        set_reg_win(6'd5);
        run_n(2, 3, 0);
        check_lock(1'b0, "R8 in run cleared by window change");
        pd_cycle(3, 0, 1'b0);
        check_lock(1'b1, "R3 lock sets after fresh in run");
    endtask

    task automatic t_zero_win();
        set_reg_win(6'd0);
        run_n(2, 1, 0);
        check_lock(1'b1, "R5 lock held during partial out run");
        pd_cycle(0, 1, 1'b0);
        check_lock(1'b0, "R2 nonzero width out-of-window at window 0");
        run_n(3, 0, 0);
        check_lock(1'b1, "R2 zero width in-window at window 0");
    endtask

    task automatic t_presets();
        set_preset(8'h00);
        run_n(3, 5, 0);
        check_lock(1'b0, "R6 narrow preset rejects 5");
        run_n(3, 4, 0);
        check_lock(1'b1, "R6 narrow preset accepts 4");
        set_preset(8'h04);
        run_n(3, 13, 0);
        check_lock(1'b0, "R6 wide preset rejects 13");
        run_n(3, 0, 12);
        check_lock(1'b1, "R6 wide preset accepts 12");
        set_preset(8'hFB);
        run_n(3, 5, 0);
        check_lock(1'b0, "R6 other bits ignored, narrow rejects 5");
        run_n(3, 4, 0);
        check_lock(1'b1, "R6 other bits ignored, narrow accepts 4");
        set_preset(8'hFF);
        run_n(3, 13, 0);
        check_lock(1'b0, "R6 other bits ignored, wide rejects 13");
        run_n(3, 12, 0);
        check_lock(1'b1, "R6 other bits ignored, wide accepts 12");
    endtask

    task automatic t_register_src();
        set_reg_win(6'd10);
        run_n(3, 11, 0);
        check_lock(1'b0, "R7 register window 10 rejects 11");
        run_n(3, 10, 0);
        check_lock(1'b1, "R7 register window 10 accepts 10");
        run_n(3, 11, 0);
        check_lock(1'b0, "R7 register window 10 rejects 11 again");
    endtask

    task automatic t_saturate();
        set_reg_win(6'd63);
        run_n(3, 70, 0);
        check_lock(1'b1, "R9 70-cycle pulse saturates to 63");
    endtask

    initial begin
        t_reset();
        t_acquire();
        t_boundary();
        t_strobe_sample();
        t_win_change();
        t_zero_win();
        t_presets();
        t_register_src();
        t_saturate();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule